// File: doc/BRIEF.md
# Reservation Station with Tagged Wakeup

This block holds renamed micro-operations that are waiting to execute. Every accepted micro-operation carries an opcode, a target execution port, an age sequence number, a destination physical tag and two source operands. The rename stage presents each source either as ready, with its value already resolved from the committed register file or from a finished reorder-buffer slot, or as pending, with the physical tag of the producer.

Pending sources listen on several tagged result buses. When a bus tag matches, the source takes the value and becomes ready. This also happens when the broadcast falls in the very cycle the micro-operation is written. Each execution port has its own picker. A picker sends out the oldest entry that has both sources ready, targets that port, and finds the port not busy. It sends at most one entry per port per cycle.

A flush discards every entry younger than a given sequence number. A stall output holds the rename stage back when the free slots cannot take a full allocation group.

Top module: `resv_station`

## Requirements
- R1: After a synchronous reset the station is empty, `stall` is low and every `dsp_vld` bit is low.
- R2: An allocated source with its ready bit set keeps the supplied value. An entry with both sources ready is presented on its port's dispatch outputs (opcode, both values, destination tag) after the second rising edge that follows its allocation.
- R3: A pending source stays unready until a valid broadcast carries its tag. It captures that bus value at the broadcast edge, and the entry dispatches at the next edge. A broadcast with any other tag leaves it waiting.
- R4: A broadcast whose tag matches a pending source of a micro-operation being allocated in the same cycle is captured at allocation.
- R5: An entry goes only to the port named by its 2-bit port field (port 0 to 3). It does not leave while that port's busy input is high, and it leaves on the edge at which busy is first seen low.
- R6: Among the ready entries for one port, the oldest leaves first, one per edge. Sequence a is older than b when bit SEQ_W-1 of (a - b) is set.
- R7: Up to four micro-operations are accepted per cycle, each into a free entry. Up to four leave per cycle, one per port.
- R8: While `flush` is high, every entry whose sequence number is younger than `flush_seq` is discarded and never dispatches. This includes entries allocated in that cycle. Entries equal to or older than `flush_seq` are kept.
- R9: `stall` is high while fewer than four entries are free. Every allocation offered in a stalled cycle is ignored.
- R10: The dispatch outputs are registered. A port whose picker found nothing shows `dsp_vld` low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_vld | input | 4 | Per-slot allocation request |
| alloc_op | input | 4x6 | Opcode per slot |
| alloc_port | input | 4x2 | Target execution port per slot |
| alloc_seq | input | 4x7 | Age sequence number per slot |
| alloc_dst | input | 4x6 | Destination physical tag per slot |
| alloc_a_rdy | input | 4 | Source A already resolved |
| alloc_a_val | input | 4x16 | Source A value when resolved |
| alloc_a_tag | input | 4x6 | Source A producer tag when pending |
| alloc_b_rdy | input | 4 | Source B already resolved |
| alloc_b_val | input | 4x16 | Source B value when resolved |
| alloc_b_tag | input | 4x6 | Source B producer tag when pending |
| bc_vld | input | 4 | Result broadcast valid per bus |
| bc_tag | input | 4x6 | Broadcast physical tag per bus |
| bc_val | input | 4x16 | Broadcast value per bus |
| port_busy | input | 4 | Execution port cannot accept this cycle |
| flush | input | 1 | Discard entries younger than flush_seq |
| flush_seq | input | 7 | Flush point sequence number |
| stall | output | 1 | Fewer free entries than an allocation group |
| dsp_vld | output | 4 | Dispatch valid per port |
| dsp_op | output | 4x6 | Dispatched opcode per port |
| dsp_a | output | 4x16 | Dispatched source A value per port |
| dsp_b | output | 4x16 | Dispatched source B value per port |
| dsp_dst | output | 4x6 | Dispatched destination tag per port |

## Verification
The bench targets these corner cases:
- A broadcast that coincides with allocation. A design that only compares tags against stored entries would leave that entry asleep forever.
- A group allocated in scrambled age order on one port. Picking by slot or entry index instead of sequence age would send the entries out in the wrong order.
- A flush in the same cycle as an allocation of a younger micro-operation. A design that checks only stored entries would let the newcomer dispatch.
- An allocation attempted while the station is nearly full. A design that accepted part of the group would place the micro-operation in a free slot and dispatch it.
- A busy port held across several cycles. This shows the entry waits, and that it leaves on the exact edge at which busy drops.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned DEF_ENTRIES = 20;
  localparam int unsigned DEF_ALLOC_W = 4;
  localparam int unsigned DEF_PORTS   = 4;
  localparam int unsigned DEF_BCAST   = 4;
  localparam int unsigned DEF_OP_W    = 6;
  localparam int unsigned DEF_DATA_W  = 16;
  localparam int unsigned DEF_TAG_W   = 6;
  localparam int unsigned DEF_SEQ_W   = 7;

  // True when sequence a precedes b in modular order of width w.
  function automatic logic seq_before(input logic [31:0] a, input logic [31:0] b,
                                      input int unsigned w);
    logic [31:0] d;
    logic [31:0] s;
    d = a - b;
    s = d >> (w - 1);
    return s[0];
  endfunction
endpackage

// File: rtl/rs_tag_match.sv
module rs_tag_match #(
  parameter int unsigned BCAST  = 4,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic [TAG_W-1:0]              tag,
  input  logic [BCAST-1:0]              bc_vld,
  input  logic [BCAST-1:0][TAG_W-1:0]   bc_tag,
  input  logic [BCAST-1:0][DATA_W-1:0]  bc_val,
  output logic                          hit,
  output logic [DATA_W-1:0]             val
);
  always_comb begin
    hit = 1'b0;
    val = '0;
    for (int j = 0; j < int'(BCAST); j++) begin
      if (bc_vld[j] && bc_tag[j] == tag) begin
        hit = 1'b1;
        val = bc_val[j];
      end
    end
  end
endmodule

// File: rtl/rs_alloc_pick.sv
module rs_alloc_pick #(
  parameter int unsigned N  = 20,
  parameter int unsigned W  = 4,
  parameter int unsigned SW = 2
) (
  input  logic [N-1:0]         free_ent,
  input  logic [W-1:0]         req,
  output logic [N-1:0]         we,
  output logic [N-1:0][SW-1:0] slot
);
  // The k-th free entry (in index order) takes allocation slot k.
  always_comb begin
    int rank;
    rank = 0;
    for (int i = 0; i < int'(N); i++) begin
      we[i]   = 1'b0;
      slot[i] = '0;
      if (free_ent[i]) begin
        if (rank < int'(W)) begin
          slot[i] = SW'(rank);
          we[i]   = req[rank];
        end
        rank = rank + 1;
      end
    end
  end
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
  parameter int unsigned N     = 20,
  parameter int unsigned SEQ_W = 7,
  parameter int unsigned IW    = 5
) (
  input  logic [N-1:0]            cand,
  input  logic [N-1:0][SEQ_W-1:0] seq,
  input  logic                    busy,
  output logic                    found,
  output logic [IW-1:0]           idx,
  output logic [N-1:0]            grant
);
  always_comb begin
    int   best;
    logic any;
    best = 0;
    any  = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (cand[i] && (!any || rs_pkg::seq_before(32'(seq[i]), 32'(seq[best]), SEQ_W))) begin
        any  = 1'b1;
        best = i;
      end
    end
    found = any && !busy;
    idx   = IW'(best);
    grant = '0;
    if (found) grant[best] = 1'b1;
  end
endmodule

// File: rtl/resv_station.sv
module resv_station #(
  parameter int unsigned ENTRIES = rs_pkg::DEF_ENTRIES,
  parameter int unsigned ALLOC_W = rs_pkg::DEF_ALLOC_W,
  parameter int unsigned PORTS   = rs_pkg::DEF_PORTS,
  parameter int unsigned BCAST   = rs_pkg::DEF_BCAST,
  parameter int unsigned OP_W    = rs_pkg::DEF_OP_W,
  parameter int unsigned DATA_W  = rs_pkg::DEF_DATA_W,
  parameter int unsigned TAG_W   = rs_pkg::DEF_TAG_W,
  parameter int unsigned SEQ_W   = rs_pkg::DEF_SEQ_W,
  localparam int unsigned PSEL_W = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [ALLOC_W-1:0]                alloc_vld,
  input  logic [ALLOC_W-1:0][OP_W-1:0]      alloc_op,
  input  logic [ALLOC_W-1:0][PSEL_W-1:0]    alloc_port,
  input  logic [ALLOC_W-1:0][SEQ_W-1:0]     alloc_seq,
  input  logic [ALLOC_W-1:0][TAG_W-1:0]     alloc_dst,
  input  logic [ALLOC_W-1:0]                alloc_a_rdy,
  input  logic [ALLOC_W-1:0][DATA_W-1:0]    alloc_a_val,
  input  logic [ALLOC_W-1:0][TAG_W-1:0]     alloc_a_tag,
  input  logic [ALLOC_W-1:0]                alloc_b_rdy,
  input  logic [ALLOC_W-1:0][DATA_W-1:0]    alloc_b_val,
  input  logic [ALLOC_W-1:0][TAG_W-1:0]     alloc_b_tag,
  input  logic [BCAST-1:0]                  bc_vld,
  input  logic [BCAST-1:0][TAG_W-1:0]       bc_tag,
  input  logic [BCAST-1:0][DATA_W-1:0]      bc_val,
  input  logic [PORTS-1:0]                  port_busy,
  input  logic                              flush,
  input  logic [SEQ_W-1:0]                  flush_seq,
  output logic                              stall,
  output logic [PORTS-1:0]                  dsp_vld,
  output logic [PORTS-1:0][OP_W-1:0]        dsp_op,
  output logic [PORTS-1:0][DATA_W-1:0]      dsp_a,
  output logic [PORTS-1:0][DATA_W-1:0]      dsp_b,
  output logic [PORTS-1:0][TAG_W-1:0]       dsp_dst
);
  localparam int unsigned IDX_W  = $clog2(ENTRIES);
  localparam int unsigned SLOT_W = (ALLOC_W > 1) ? $clog2(ALLOC_W) : 1;

  // Entry storage
  logic [ENTRIES-1:0]              v, ra, rb;
  logic [ENTRIES-1:0][SEQ_W-1:0]   seq_q;
  logic [OP_W-1:0]                 op_q   [ENTRIES];
  logic [PSEL_W-1:0]               psel_q [ENTRIES];
  logic [TAG_W-1:0]                dst_q  [ENTRIES];
  logic [TAG_W-1:0]                ta     [ENTRIES];
  logic [TAG_W-1:0]                tb     [ENTRIES];
  logic [DATA_W-1:0]               va     [ENTRIES];
  logic [DATA_W-1:0]               vb     [ENTRIES];

  // Wakeup results for stored entries and for incoming slots
  logic [ENTRIES-1:0]              hit_a, hit_b;
  logic [DATA_W-1:0]               hv_a [ENTRIES];
  logic [DATA_W-1:0]               hv_b [ENTRIES];
  logic [ALLOC_W-1:0]              ahit_a, ahit_b;
  logic [DATA_W-1:0]               ahv_a [ALLOC_W];
  logic [DATA_W-1:0]               ahv_b [ALLOC_W];

  logic [ENTRIES-1:0]              kill, we, grant_any;
  logic [ALLOC_W-1:0]              akill, req;
  logic [ENTRIES-1:0][SLOT_W-1:0]  slot;
  logic [PORTS-1:0][ENTRIES-1:0]   cand, grant;
  logic [PORTS-1:0]                found;
  logic [PORTS-1:0][IDX_W-1:0]     idx;

  always_comb begin
    stall = (int'($countones(v)) + int'(ALLOC_W)) > int'(ENTRIES);
    req   = alloc_vld & {ALLOC_W{~stall}};
  end

  for (genvar i = 0; i < int'(ENTRIES); i++) begin : g_ent
    rs_tag_match #(.BCAST(BCAST), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_wa (
      .tag(ta[i]), .bc_vld(bc_vld), .bc_tag(bc_tag), .bc_val(bc_val),
      .hit(hit_a[i]), .val(hv_a[i]));
    rs_tag_match #(.BCAST(BCAST), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_wb (
      .tag(tb[i]), .bc_vld(bc_vld), .bc_tag(bc_tag), .bc_val(bc_val),
      .hit(hit_b[i]), .val(hv_b[i]));
    assign kill[i] = flush && rs_pkg::seq_before(32'(flush_seq), 32'(seq_q[i]), SEQ_W);
  end

  for (genvar k = 0; k < int'(ALLOC_W); k++) begin : g_slot
    rs_tag_match #(.BCAST(BCAST), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_aa (
      .tag(alloc_a_tag[k]), .bc_vld(bc_vld), .bc_tag(bc_tag), .bc_val(bc_val),
      .hit(ahit_a[k]), .val(ahv_a[k]));
    rs_tag_match #(.BCAST(BCAST), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ab (
      .tag(alloc_b_tag[k]), .bc_vld(bc_vld), .bc_tag(bc_tag), .bc_val(bc_val),
      .hit(ahit_b[k]), .val(ahv_b[k]));
    assign akill[k] = flush && rs_pkg::seq_before(32'(flush_seq), 32'(alloc_seq[k]), SEQ_W);
  end

  rs_alloc_pick #(.N(ENTRIES), .W(ALLOC_W), .SW(SLOT_W)) u_alloc (
    .free_ent(~v), .req(req), .we(we), .slot(slot));

  for (genvar p = 0; p < int'(PORTS); p++) begin : g_port
    always_comb begin
      for (int i = 0; i < int'(ENTRIES); i++)
        cand[p][i] = v[i] && ra[i] && rb[i] && !kill[i] && (psel_q[i] == PSEL_W'(p));
    end
    rs_age_pick #(.N(ENTRIES), .SEQ_W(SEQ_W), .IW(IDX_W)) u_pick (
      .cand(cand[p]), .seq(seq_q), .busy(port_busy[p]),
      .found(found[p]), .idx(idx[p]), .grant(grant[p]));
  end

  always_comb begin
    for (int i = 0; i < int'(ENTRIES); i++) begin
      grant_any[i] = 1'b0;
      for (int p = 0; p < int'(PORTS); p++) grant_any[i] = grant_any[i] | grant[p][i];
    end
  end

  // Entry update: write, wakeup, release
  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(ENTRIES); i++) begin
      if (rst) begin
        v[i] <= 1'b0;
      end else if (we[i]) begin
        v[i]      <= !akill[slot[i]];
        op_q[i]   <= alloc_op[slot[i]];
        psel_q[i] <= alloc_port[slot[i]];
        seq_q[i]  <= alloc_seq[slot[i]];
        dst_q[i]  <= alloc_dst[slot[i]];
        ta[i]     <= alloc_a_tag[slot[i]];
        tb[i]     <= alloc_b_tag[slot[i]];
        ra[i]     <= alloc_a_rdy[slot[i]] | ahit_a[slot[i]];
        rb[i]     <= alloc_b_rdy[slot[i]] | ahit_b[slot[i]];
        va[i]     <= alloc_a_rdy[slot[i]] ? alloc_a_val[slot[i]] : ahv_a[slot[i]];
        vb[i]     <= alloc_b_rdy[slot[i]] ? alloc_b_val[slot[i]] : ahv_b[slot[i]];
      end else begin
        if (grant_any[i] || kill[i]) v[i] <= 1'b0;
        if (!ra[i] && hit_a[i]) begin
          ra[i] <= 1'b1;
          va[i] <= hv_a[i];
        end
        if (!rb[i] && hit_b[i]) begin
          rb[i] <= 1'b1;
          vb[i] <= hv_b[i];
        end
      end
    end
  end

  // Registered dispatch buses
  always_ff @(posedge clk) begin
    for (int p = 0; p < int'(PORTS); p++) begin
      if (rst) dsp_vld[p] <= 1'b0;
      else     dsp_vld[p] <= found[p];
      dsp_op[p]  <= op_q[idx[p]];
      dsp_a[p]   <= va[idx[p]];
      dsp_b[p]   <= vb[idx[p]];
      dsp_dst[p] <= dst_q[idx[p]];
    end
  end

  // Assertions
  p_stall_no_growth_r9: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush) |=> ($countones(v) <= $past($countones(v))));

  for (genvar i = 0; i < int'(ENTRIES); i++) begin : g_chk_ent
    p_alloc_into_free_r7: assert property (@(posedge clk) disable iff (rst)
      we[i] |-> !v[i]);
    p_issue_only_ready_r3: assert property (@(posedge clk) disable iff (rst)
      grant_any[i] |-> (ra[i] && rb[i]));
    p_flush_drops_young_r8: assert property (@(posedge clk) disable iff (rst)
      $past(flush) |-> !(v[i] && rs_pkg::seq_before(32'($past(flush_seq)), 32'(seq_q[i]), SEQ_W)));
  end

  for (genvar p = 0; p < int'(PORTS); p++) begin : g_chk_port
    p_busy_port_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      dsp_vld[p] |-> !$past(port_busy[p]));
  end
endmodule

// File: tb/sim_resv_station.sv
module sim_resv_station;
  localparam int AW = 4, NP = 4, NB = 4, OPW = 6, DW = 16, TW = 6, SW = 7, PW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0]          alloc_vld;
  logic [AW-1:0][OPW-1:0] alloc_op;
  logic [AW-1:0][PW-1:0]  alloc_port;
  logic [AW-1:0][SW-1:0]  alloc_seq;
  logic [AW-1:0][TW-1:0]  alloc_dst;
  logic [AW-1:0]          alloc_a_rdy, alloc_b_rdy;
  logic [AW-1:0][DW-1:0]  alloc_a_val, alloc_b_val;
  logic [AW-1:0][TW-1:0]  alloc_a_tag, alloc_b_tag;
  logic [NB-1:0]          bc_vld;
  logic [NB-1:0][TW-1:0]  bc_tag;
  logic [NB-1:0][DW-1:0]  bc_val;
  logic [NP-1:0]          port_busy;
  logic                   flush;
  logic [SW-1:0]          flush_seq;
  logic                   stall;
  logic [NP-1:0]          dsp_vld;
  logic [NP-1:0][OPW-1:0] dsp_op;
  logic [NP-1:0][DW-1:0]  dsp_a, dsp_b;
  logic [NP-1:0][TW-1:0]  dsp_dst;

  int checks = 0, fails = 0;
  int sq = 0;

  always #5 clk = ~clk;

  resv_station u0 (
    .clk(clk), .rst(rst), .alloc_vld(alloc_vld), .alloc_op(alloc_op), .alloc_port(alloc_port),
    .alloc_seq(alloc_seq), .alloc_dst(alloc_dst), .alloc_a_rdy(alloc_a_rdy),
    .alloc_a_val(alloc_a_val), .alloc_a_tag(alloc_a_tag), .alloc_b_rdy(alloc_b_rdy),
    .alloc_b_val(alloc_b_val), .alloc_b_tag(alloc_b_tag), .bc_vld(bc_vld), .bc_tag(bc_tag),
    .bc_val(bc_val), .port_busy(port_busy), .flush(flush), .flush_seq(flush_seq),
    .stall(stall), .dsp_vld(dsp_vld), .dsp_op(dsp_op), .dsp_a(dsp_a), .dsp_b(dsp_b),
    .dsp_dst(dsp_dst));

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    alloc_vld = '0; alloc_op = '0; alloc_port = '0; alloc_seq = '0; alloc_dst = '0;
    alloc_a_rdy = '0; alloc_a_val = '0; alloc_a_tag = '0;
    alloc_b_rdy = '0; alloc_b_val = '0; alloc_b_tag = '0;
    bc_vld = '0; bc_tag = '0; bc_val = '0; port_busy = '0; flush = 1'b0; flush_seq = '0;
  endtask

  task automatic put(input int k, input int op, input int prt, input int seq, input int dst,
                     input bit ard, input int aval, input int atag,
                     input bit brd, input int bval, input int btag);
    alloc_vld[k] = 1'b1; alloc_op[k] = OPW'(op); alloc_port[k] = PW'(prt);
    alloc_seq[k] = SW'(seq); alloc_dst[k] = TW'(dst);
    alloc_a_rdy[k] = ard; alloc_a_val[k] = DW'(aval); alloc_a_tag[k] = TW'(atag);
    alloc_b_rdy[k] = brd; alloc_b_val[k] = DW'(bval); alloc_b_tag[k] = TW'(btag);
  endtask

  task automatic bcast(input int j, input int tag, input int val);
    bc_vld[j] = 1'b1; bc_tag[j] = TW'(tag); bc_val[j] = DW'(val);
  endtask

  task automatic t_reset();
    chk("R1", "stall", 32'(stall), 0);
    chk("R1", "dsp_vld", 32'(dsp_vld), 0);
  endtask

  task automatic t_ready_alloc();
    put(0, 5, 0, sq, 10, 1, 'h1111, 0, 1, 'h2222, 0); sq++;
    tick(); idle();
    chk("R10", "no dispatch one edge after alloc", 32'(dsp_vld), 0);
    tick();
    chk("R2", "dsp_vld[0]", 32'(dsp_vld[0]), 1);
    chk("R2", "dsp_op", 32'(dsp_op[0]), 5);
    chk("R2", "dsp_a", 32'(dsp_a[0]), 'h1111);
    chk("R2", "dsp_b", 32'(dsp_b[0]), 'h2222);
    chk("R2", "dsp_dst", 32'(dsp_dst[0]), 10);
    tick();
    chk("R10", "vld drops when empty", 32'(dsp_vld), 0);
  endtask

  task automatic t_wakeup();
    put(0, 1, 0, sq, 40, 0, 0, 5, 1, 'h0011, 0); sq++;
    put(1, 2, 1, sq, 41, 0, 0, 9, 1, 'h0022, 0); sq++;
    tick(); idle(); tick(); tick();
    chk("R3", "pending stays quiet", 32'(dsp_vld), 0);
    bcast(2, 5, 'h1234);
    tick(); idle();
    chk("R3", "no dispatch at capture edge", 32'(dsp_vld), 0);
    tick();
    chk("R3", "woken dsp_vld", 32'(dsp_vld), 'b0001);
    chk("R3", "woken value", 32'(dsp_a[0]), 'h1234);
    chk("R3", "ready value kept", 32'(dsp_b[0]), 'h0011);
    bcast(0, 9, 'h0abc);
    tick(); idle(); tick();
    chk("R3", "second wake dsp_vld", 32'(dsp_vld), 'b0010);
    chk("R3", "second wake value", 32'(dsp_a[1]), 'h0abc);
    tick();
  endtask

  task automatic t_same_cycle();
    put(2, 7, 3, sq, 45, 1, 'h0505, 0, 0, 0, 7); sq++;
    bcast(3, 7, 'hbeef);
    tick(); idle(); tick();
    chk("R4", "dsp_vld[3]", 32'(dsp_vld[3]), 1);
    chk("R4", "captured b", 32'(dsp_b[3]), 'hbeef);
    tick();
  endtask

  task automatic t_oldest();
    put(0, 3, 1, sq + 2, 30, 1, 1, 0, 1, 1, 0);
    put(1, 3, 1, sq,     31, 1, 2, 0, 1, 2, 0);
    put(2, 3, 1, sq + 1, 32, 1, 3, 0, 1, 3, 0);
    sq += 3;
    tick(); idle(); tick();
    chk("R6", "first dst", 32'(dsp_dst[1]), 31);
    tick();
    chk("R6", "second dst", 32'(dsp_dst[1]), 32);
    tick();
    chk("R6", "third dst", 32'(dsp_dst[1]), 30);
    chk("R6", "third vld", 32'(dsp_vld[1]), 1);
    tick();
    chk("R6", "drained", 32'(dsp_vld), 0);
  endtask

  task automatic t_busy();
    port_busy[2] = 1'b1;
    put(0, 4, 2, sq, 33, 1, 9, 0, 1, 9, 0); sq++;
    tick(); alloc_vld = '0; tick(); tick(); tick();
    chk("R5", "held while busy", 32'(dsp_vld), 0);
    port_busy[2] = 1'b0;
    tick();
    chk("R5", "leaves on release", 32'(dsp_vld), 'b0100);
    chk("R5", "dst on port 2", 32'(dsp_dst[2]), 33);
    tick();
  endtask

  task automatic t_wide();
    for (int k = 0; k < AW; k++) begin
      put(k, 8 + k, 3 - k, sq, 20 + k, 1, k, 0, 1, k, 0); sq++;
    end
    tick(); idle(); tick();
    chk("R7", "four issued", 32'(dsp_vld), 'hf);
    for (int p = 0; p < NP; p++) chk("R7", "dst per port", 32'(dsp_dst[p]), 32'(23 - p));
    tick();
    chk("R7", "all gone", 32'(dsp_vld), 0);
  endtask

  task automatic t_flush();
    int s0;
    s0 = sq;
    for (int k = 0; k < 3; k++) put(k, 1, k, s0 + k, 50 + k, 0, 0, 12, 1, 0, 0);
    sq += 3;
    tick(); idle();
    flush = 1'b1; flush_seq = SW'(s0);
    put(0, 1, 3, s0 + 3, 53, 1, 0, 0, 1, 0, 0); sq++;
    tick(); idle();
    bcast(1, 12, 'h7777);
    tick(); idle();
    chk("R8", "flushed newcomer silent", 32'(dsp_vld), 0);
    tick();
    chk("R8", "only survivor issues", 32'(dsp_vld), 'b0001);
    chk("R8", "survivor dst", 32'(dsp_dst[0]), 50);
    tick();
    chk("R8", "nothing after", 32'(dsp_vld), 0);
  endtask

  task automatic t_stall();
    int s0;
    s0 = sq;
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < AW; k++) begin
        put(k, 0, 0, sq, 60, 0, 0, 63, 0, 0, 63); sq++;
      end
      tick(); idle();
    end
    chk("R9", "no stall at four free", 32'(stall), 0);
    put(0, 0, 0, sq, 60, 0, 0, 63, 0, 0, 63); sq++;
    tick(); idle();
    chk("R9", "stall at three free", 32'(stall), 1);
    put(0, 2, 1, sq, 61, 1, 1, 0, 1, 1, 0); sq++;
    tick(); idle(); tick();
    chk("R9", "stalled alloc ignored", 32'(dsp_vld), 0);
    chk("R9", "still stalled", 32'(stall), 1);
    flush = 1'b1; flush_seq = SW'(s0 - 1);
    tick(); idle();
    chk("R9", "stall clears after flush", 32'(stall), 0);
    tick();
    chk("R8", "flushed all quiet", 32'(dsp_vld), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_ready_alloc();
    t_wakeup();
    t_same_cycle();
    t_oldest();
    t_busy();
    t_wide();
    t_flush();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule